// File: doc/BRIEF.md
# Refresh Row Walker with Pause and Resume

This block sits on the memory-device side of a refresh path. Each refresh pulse refreshes a bundle of consecutive rows. The block issues those rows one at a time to the row-refresh machinery, which acknowledges each row with a done strobe. Inside the block, a global row pointer marks the first row of the current bundle, and an in-bundle offset counter marks the current row within it.

The controller can pause a bundle at any time by pulling the refresh-enable level low. The signalling runs one way only, from the controller to the device. A row that has already been requested always runs to completion, because stopping a row part way through could lose data. The offset counter's increment is gated by the refresh-enable level. While the level is low, the walker therefore holds at the row it last completed. When the level goes high again, the walker issues the following row. After the last row of the bundle, the global pointer moves on to the next bundle and a one-cycle completion flag is raised.

Top module: `rfsh_row_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rowReq` and `bundleDone` are 0 and `rowAddr` is 0. Reset clears both the global pointer and the offset.
- R2: A `pulseStart` high in an idle cycle makes `rowReq` 1 in the next cycle, with `rowAddr` equal to the first row of the bundle (the global pointer).
- R3: While `rowReq` is 1 and `rowDone` is 0, `rowReq` stays 1 and `rowAddr` stays unchanged in the next cycle.
- R4: When `rowDone` completes a row that is not the bundle's last, and `refreshEn` is 1, `rowReq` is 0 for exactly one cycle. In that cycle `rowAddr` still shows the completed row. In the following cycle `rowReq` is 1 and `rowAddr` is the completed row plus one.
- R5: A low `refreshEn` during a requested row does not withdraw the row. `rowReq` stays 1 until `rowDone`.
- R6: While `refreshEn` is 0 between rows, `rowReq` stays 0 and `rowAddr` holds the last completed row. One cycle after `refreshEn` returns to 1, `rowReq` is 1 and `rowAddr` is that row plus one.
- R7: The `rowDone` for offset `BUNDLE_ROWS-1` raises `bundleDone` for exactly one cycle, in the next cycle. `rowReq` is 0 in that cycle, and `rowAddr` equals the old pointer plus `BUNDLE_ROWS`. The block is then idle.
- R8: A `pulseStart` that arrives while a bundle is in progress, whether during a row or in a gap between rows, is ignored. Neither the address nor the row sequence changes.
- R9: While idle, `refreshEn` and `rowDone` have no effect. `rowReq` stays 0 and `rowAddr` is unchanged.
- R10: The global pointer wraps modulo 2^`ROW_W`. After the bundle that ends at the top of the address space, `rowAddr` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseStart | input | 1 | Strobe that starts a bundle refresh |
| refreshEn | input | 1 | Refresh-enable level; low pauses, high resumes |
| rowDone | input | 1 | Strobe that marks the requested row as finished |
| rowAddr | output | ROW_W | Address of the current or last completed row |
| rowReq | output | 1 | Row-refresh request, held until rowDone |
| bundleDone | output | 1 | One-cycle flag after the bundle's last row |

## Verification
On every cycle, the bound checker enforces the following properties. A held request keeps its row address. A low enable outside a running row neither starts a row nor moves the address. The completion flag never lasts more than one cycle and never coincides with a request. A paused row still running to completion is covered by the request-hold property.

Some behaviours need knowledge of the bundle's position and are therefore shown only by the bench's directed scenarios:
- the exact resume address after a pause;
- the increment by one between rows;
- the advance of the global pointer and its wrap;
- the ignoring of stray start strobes in the middle of a bundle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_GAP  = 2'd2
  } rfshState_t;

  typedef struct packed {
    logic clrOffset;
    logic incOffset;
    logic advanceBase;
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_row_ctrl.sv
module rfsh_row_ctrl
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pulseStart,
  input  logic        refreshEn,
  input  logic        rowDone,
  input  logic        lastRow,
  output rfshStrobe_t strobe,
  output logic        rowReq,
  output logic        bundleDone
);

  rfshState_t stateQ, stateD;
  logic       doneD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (pulseStart) begin
          strobe.clrOffset = 1'b1;
          stateD           = ST_ROW;
        end
      end
      ST_ROW: begin
        if (rowDone) begin
          if (lastRow) begin
            strobe.advanceBase = 1'b1;
            strobe.clrOffset   = 1'b1;
            doneD              = 1'b1;
            stateD             = ST_IDLE;
          end else begin
            stateD = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        // The datapath ANDs this request with refreshEn.
        strobe.incOffset = 1'b1;
        if (refreshEn) stateD = ST_ROW;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      bundleDone <= 1'b0;
    end else begin
      stateQ     <= stateD;
      bundleDone <= doneD;
    end
  end

  assign rowReq = (stateQ == ST_ROW);

endmodule

// File: rtl/rfsh_row_dp.sv
module rfsh_row_dp
  import rfsh_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int BUNDLE_ROWS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refreshEn,
  input  rfshStrobe_t      strobe,
  output logic             lastRow,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int OFF_W = (BUNDLE_ROWS > 1) ? $clog2(BUNDLE_ROWS) : 1;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BUNDLE_ROWS - 1);
  localparam logic [ROW_W-1:0] BASE_STEP = ROW_W'(BUNDLE_ROWS);
  localparam bit POW2 = (BUNDLE_ROWS > 1) && ((BUNDLE_ROWS & (BUNDLE_ROWS - 1)) == 0);

  logic [ROW_W-1:0] basePtr;
  logic [OFF_W-1:0] offset;
  logic             incGate;

  // Incrementer enable gated by the refresh-enable level.
  assign incGate = strobe.incOffset & refreshEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset <= '0;
    end else if (strobe.clrOffset) begin
      offset <= '0;
    end else if (incGate) begin
      offset <= offset + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
    end else if (strobe.advanceBase) begin
      basePtr <= basePtr + BASE_STEP;
    end
  end

  assign lastRow = (offset == LAST_OFF);

  generate
    if (POW2) begin : g_concat
      // The base stays bundle-aligned, so the offset fills the low bits.
      assign rowAddr = {basePtr[ROW_W-1:OFF_W], offset};
    end else begin : g_adder
      assign rowAddr = basePtr + ROW_W'(offset);
    end
  endgenerate

endmodule

// File: rtl/rfsh_row_gen.sv
module rfsh_row_gen
  import rfsh_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int BUNDLE_ROWS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseStart,
  input  logic             refreshEn,
  input  logic             rowDone,
  output logic [ROW_W-1:0] rowAddr,
  output logic             rowReq,
  output logic             bundleDone
);

  rfshStrobe_t strobe;
  logic        lastRow;

  rfsh_row_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pulseStart (pulseStart),
    .refreshEn  (refreshEn),
    .rowDone    (rowDone),
    .lastRow    (lastRow),
    .strobe     (strobe),
    .rowReq     (rowReq),
    .bundleDone (bundleDone)
  );

  rfsh_row_dp #(
    .ROW_W       (ROW_W),
    .BUNDLE_ROWS (BUNDLE_ROWS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refreshEn (refreshEn),
    .strobe    (strobe),
    .lastRow   (lastRow),
    .rowAddr   (rowAddr)
  );

endmodule

// File: rtl/rfsh_row_gen_checker.sv
module rfsh_row_gen_checker #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pulseStart,
  input logic             refreshEn,
  input logic             rowDone,
  input logic [ROW_W-1:0] rowAddr,
  input logic             rowReq,
  input logic             bundleDone
);

  // R3, R5: a request is held until its done strobe, whatever refreshEn does
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    rowReq && !rowDone |=> rowReq);

  // R3: the address of a held request does not move
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    rowReq && !rowDone |=> $stable(rowAddr));

  // R6, R9: a low enable outside a row starts nothing
  assert_pause_no_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rowReq && !refreshEn && !pulseStart |=> !rowReq);

  // R6, R9: a low enable outside a row freezes the address
  assert_pause_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rowReq && !refreshEn && !pulseStart |=> $stable(rowAddr));

  // R7: the completion flag lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    bundleDone |=> !bundleDone);

  // R7: the completion flag never overlaps a request
  assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    bundleDone |-> !rowReq);

endmodule

bind rfsh_row_gen rfsh_row_gen_checker #(.ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pulseStart (pulseStart),
  .refreshEn  (refreshEn),
  .rowDone    (rowDone),
  .rowAddr    (rowAddr),
  .rowReq     (rowReq),
  .bundleDone (bundleDone)
);

// File: tb/rfsh_row_gen_bench.sv
module rfsh_row_gen_bench;

  localparam int ROW_W  = 6;
  localparam int BUNDLE = 8;
  localparam int SPAN   = 1 << ROW_W;

  logic             clk = 1'b0;
  logic             rstN;
  logic             pulseStart;
  logic             refreshEn;
  logic             rowDone;
  logic [ROW_W-1:0] rowAddr;
  logic             rowReq;
  logic             bundleDone;

  int checkCnt = 0;
  int failCnt  = 0;
  int expBase  = 0;
  int expOff   = 0;

  always #4 clk = ~clk;

  rfsh_row_gen #(.ROW_W(ROW_W), .BUNDLE_ROWS(BUNDLE)) u_rfsh_row_gen (
    .clk        (clk),
    .rstN       (rstN),
    .pulseStart (pulseStart),
    .refreshEn  (refreshEn),
    .rowDone    (rowDone),
    .rowAddr    (rowAddr),
    .rowReq     (rowReq),
    .bundleDone (bundleDone)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int curAddr();
    return (expBase + expOff) % SPAN;
  endfunction

  task automatic startBundle();
    pulseStart = 1'b1;
    tick();
    pulseStart = 1'b0;
    expOff = 0;
    check("R2 rowReq after start", int'(rowReq), 1);
    check("R2 first row address", int'(rowAddr), expBase);
  endtask

  // Finishes the current row with refreshEn held high.
  task automatic finishRow();
    rowDone = 1'b1;
    tick();
    rowDone = 1'b0;
    if (expOff == BUNDLE - 1) begin
      expBase = (expBase + BUNDLE) % SPAN;
      check("R7 bundleDone raised", int'(bundleDone), 1);
      check("R7 rowReq low at end", int'(rowReq), 0);
      check("R7 pointer advanced", int'(rowAddr), expBase);
      if (expBase == 0) check("R10 pointer wrapped", int'(rowAddr), 0);
      tick();
      check("R7 bundleDone one cycle", int'(bundleDone), 0);
      check("R7 idle after bundle", int'(rowReq), 0);
      expOff = 0;
    end else begin
      check("R4 gap cycle rowReq", int'(rowReq), 0);
      check("R4 gap shows completed row", int'(rowAddr), curAddr());
      tick();
      expOff++;
      check("R4 next row requested", int'(rowReq), 1);
      check("R4 next row address", int'(rowAddr), curAddr());
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; pulseStart = 1'b0; refreshEn = 1'b1; rowDone = 1'b0;
    repeat (3) tick();
    check("R1 rowReq in reset", int'(rowReq), 0);
    check("R1 bundleDone in reset", int'(bundleDone), 0);
    rstN = 1'b1;
    tick();
    check("R1 rowReq after reset", int'(rowReq), 0);
    check("R1 rowAddr after reset", int'(rowAddr), 0);
  endtask

  task automatic testIdleIgnore();
    refreshEn = 1'b0;
    tick();
    rowDone = 1'b1;
    tick();
    rowDone = 1'b0;
    refreshEn = 1'b1;
    tick();
    rowDone = 1'b1;
    tick();
    rowDone = 1'b0;
    check("R9 idle rowReq", int'(rowReq), 0);
    check("R9 idle rowAddr", int'(rowAddr), expBase);
    check("R9 idle bundleDone", int'(bundleDone), 0);
  endtask

  task automatic testHold();
    startBundle();
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R3 request held", int'(rowReq), 1);
      check("R3 address held", int'(rowAddr), curAddr());
    end
    finishRow();
  endtask

  task automatic testPause();
    refreshEn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 row not withdrawn", int'(rowReq), 1);
    end
    rowDone = 1'b1;
    tick();
    rowDone = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R6 paused rowReq", int'(rowReq), 0);
      check("R6 paused address", int'(rowAddr), curAddr());
    end
    refreshEn = 1'b1;
    tick();
    expOff++;
    check("R6 resumed rowReq", int'(rowReq), 1);
    check("R6 resumed address", int'(rowAddr), curAddr());
  endtask

  task automatic testStrayStart();
    pulseStart = 1'b1;
    tick();
    pulseStart = 1'b0;
    check("R8 start during row", int'(rowAddr), curAddr());
    check("R8 row still requested", int'(rowReq), 1);
    refreshEn = 1'b0;
    rowDone = 1'b1;
    tick();
    rowDone = 1'b0;
    pulseStart = 1'b1;
    tick();
    pulseStart = 1'b0;
    check("R8 start during gap rowReq", int'(rowReq), 0);
    check("R8 start during gap address", int'(rowAddr), curAddr());
    refreshEn = 1'b1;
    tick();
    expOff++;
    check("R8 sequence continues", int'(rowAddr), curAddr());
  endtask

  task automatic runBundle();
    startBundle();
    for (int i = 0; i < BUNDLE; i++) finishRow();
  endtask

  task automatic testWrap();
    while (expBase != 0) runBundle();
    check("R10 wrap to zero", int'(rowAddr), 0);
    runBundle();
    check("R10 after wrap", int'(rowAddr), BUNDLE);
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    testReset();
    testIdleIgnore();
    testHold();
    testPause();
    testStrayStart();
    while (expOff != 0) finishRow();
    testIdleIgnore();
    runBundle();
    testWrap();
    finish();
  end

endmodule